// File: doc/BRIEF.md
# Conductance Drift Pipeline

This block ages the stored conductance of emulated phase-change cells. A stream of cells enters one per clock. Each cell carries its conductance at reference time t0, its own drift exponent nu, and the ratio t/t0. The block returns G(t) = G(t0)·(t/t0)^(−nu). It takes a natural log of the ratio, multiplies by −nu, raises e to the result, and scales the stored conductance by that factor. Fixed-point arithmetic and two small generated tables carry out the log and exponential steps. The datapath has five register stages and takes a new cell on every clock.

Conductances are unsigned Q8.16 in microsiemens (24 bits). The time ratio is unsigned Q16.16 (32 bits), and drift exponents are signed Q4.12 (16 bits). If the ratio is at or below 1.0, the stored conductance passes through unchanged. A result above the conductance range clamps at the maximum code and never wraps.

Both streams use valid/ready handshakes. A cell is taken on a clock edge when `in_valid` and `in_ready` are both high. A result leaves on an edge when `out_valid` and `out_ready` are both high. With `out_ready` low and a result waiting, the whole pipeline freezes: `in_ready` drops, and the output holds its value.

A separate helper hands out per-cell drift exponents when cells are initialised. Each `draw` pulse latches a new value near `cfg_nu_mean`, spread by `cfg_nu_sigma`. The spread is approximately Gaussian and comes from a sum of twelve free-running pseudo-random uniform words. Software gives these exponents to the datapath.

Top module: `drift_emu_pipe`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_g` keeps its value on the next clock.
- R2: Results leave in the order cells were accepted, and none appears without an accepted cell. With `out_ready` held high, each result is on `out_valid`/`out_g` after the fifth rising edge following its accept edge, and one cell per clock passes back to back.
- R3: When `in_ratio` ≤ 0x0001_0000 (t/t0 ≤ 1.0), `out_g` equals `in_g0` bit for bit, for any `in_nu`.
- R4: When `in_ratio` > 0x0001_0000 and the true result lies in range, `out_g` is within 3 % + 2 LSB of G·(t/t0)^(−nu), with `in_g0` read as Q8.16, `in_nu` as signed Q4.12 and `in_ratio` as Q16.16.
- R5: When the true result reaches 2^24 LSB or more, `out_g` is 0xFF_FFFF. When `in_g0` is 0, `out_g` is 0 for any exponent or ratio.
- R6: After reset, `out_valid` is low, `in_ready` is high and `nu_draw` is 0.
- R7: `nu_draw` changes only on an edge where `draw` is high, and keeps its value while `draw` is low. Successive draws with nonzero sigma give new values.
- R8: With `cfg_nu_sigma` = 0, a draw sets `nu_draw` to exactly `cfg_nu_mean`.
- R9: With mean 0 and sigma 1.0 (0x1000), the average of 400 draws lies within ±0.25 and their variance lies between 0.3 and 2.0. Every draw lies within mean ± 6·sigma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Cell present on the input |
| in_ready | output | 1 | Block can take a cell this clock |
| in_g0 | input | 24 | Conductance at t0, unsigned Q8.16 µS |
| in_nu | input | 16 | Drift exponent, signed Q4.12 |
| in_ratio | input | 32 | Time ratio t/t0, unsigned Q16.16 |
| out_valid | output | 1 | Result present on the output |
| out_ready | input | 1 | Downstream takes the result this clock |
| out_g | output | 24 | Conductance at t, unsigned Q8.16 µS |
| cfg_nu_mean | input | 16 | Exponent mean for draws, signed Q4.12 |
| cfg_nu_sigma | input | 16 | Exponent standard deviation, signed Q4.12 |
| draw | input | 1 | Latch a new random exponent this clock |
| nu_draw | output | 16 | Last drawn exponent, signed Q4.12 |

## Verification
A conductance result is due on the fifth rising edge after its accept edge, provided `out_ready` stays high. A drawn exponent shows on the first edge after the `draw` pulse. The bench drives inputs and reads outputs at falling edges. It stamps each accepted cell with the falling-edge count. While no back-pressure is applied, it requires the matching result exactly five counts later. During random back-pressure it keeps only order and value checks, and it checks that a held result is unchanged one clock later. Each exponent draw is read at the first falling edge after its pulse.

// File: rtl/drift_pkg.sv
package drift_pkg;
  // Fractional bits of the internal log / exponent values
  localparam int  LN_FRAC   = 16;
  localparam real LN2_REAL  = 0.6931471805599453;
  localparam int  LN2_Q     = $rtoi(LN2_REAL * (2.0 ** LN_FRAC) + 0.5);
  localparam int  INV_LN2_Q = $rtoi((1.0 / LN2_REAL) * (2.0 ** LN_FRAC) + 0.5);
endpackage

// File: rtl/drift_log.sv
// Natural log of an unsigned fixed-point ratio: octave from the leading one,
// fine part from a generated table on the bits below it (midpoint entries).
module drift_log
  import drift_pkg::*;
#(
  parameter int RW  = 32,
  parameter int RF  = 16,
  parameter int LB  = 6,
  parameter int LNW = 32
) (
  input  logic [RW-1:0]         ratio,
  output logic signed [LNW-1:0] ln_val
);
  localparam int LN = 1 << LB;
  localparam int PW = $clog2(RW);

  logic [LN_FRAC-1:0] lut [LN];
  for (genvar i = 0; i < LN; i++) begin : g_lut
    assign lut[i] = LN_FRAC'($rtoi($ln(1.0 + (real'(i) + 0.5) / real'(LN))
                                   * (2.0 ** LN_FRAC) + 0.5));
  end

  logic [PW-1:0] msb;
  logic [RW-1:0] norm;
  logic [LB-1:0] idx;

  always_comb begin
    msb = '0;
    for (int b = 0; b < RW; b++) begin
      if (ratio[b]) msb = PW'(b);
    end
    norm   = ratio << (PW'(RW - 1) - msb);
    idx    = LB'(norm >> (RW - 1 - LB));
    ln_val = $signed(LNW'((int'(msb) - RF) * LN2_Q)) + $signed(LNW'({1'b0, lut[idx]}));
  end
endmodule

// File: rtl/drift_exp.sv
// Scales a conductance by 2^z (z already multiplied by 1/ln2), saturating.
module drift_exp
  import drift_pkg::*;
#(
  parameter int GW = 24,
  parameter int ZW = 48,
  parameter int LB = 6
) (
  input  logic [GW-1:0]        g_in,
  input  logic signed [ZW-1:0] z,
  output logic [GW-1:0]        g_out
);
  localparam int LN  = 1 << LB;
  localparam int MW  = LN_FRAC + 2;
  localparam int PW  = GW + MW;
  localparam int WW  = PW + GW + 1;
  localparam int SHW = $clog2(GW + 1);
  localparam int NSW = $clog2(PW + LN_FRAC + 2);
  localparam logic [GW-1:0] GMAX = '1;

  logic [MW-1:0] lut [LN];
  for (genvar i = 0; i < LN; i++) begin : g_lut
    assign lut[i] = MW'($rtoi((2.0 ** ((real'(i) + 0.5) / real'(LN)))
                              * (2.0 ** LN_FRAC) + 0.5));
  end

  logic signed [ZW-1:0] k, nk;
  logic [LB-1:0]        idx;
  logic [PW-1:0]        prod;
  logic [WW-1:0]        wide;

  always_comb begin
    k     = z >>> LN_FRAC;
    nk    = -k;
    idx   = z[LN_FRAC-1 -: LB];
    prod  = PW'(g_in) * PW'(lut[idx]);
    wide  = '0;
    g_out = '0;
    if (!k[ZW-1] && (k > ZW'(GW))) begin
      g_out = (prod != '0) ? GMAX : '0;
    end else if (!k[ZW-1]) begin
      wide = (WW'(prod) << k[SHW-1:0]) >> LN_FRAC;
      g_out = (wide > WW'(GMAX)) ? GMAX : wide[GW-1:0];
    end else if (nk <= ZW'(PW)) begin
      g_out = GW'(prod >> (NSW'(LN_FRAC) + nk[NSW-1:0]));
    end
  end
endmodule

// File: rtl/drift_nu_src.sv
// Approximate Gaussian exponent source: sum of uniform LFSR words,
// centred, scaled by sigma, offset by the mean, clamped to the format.
module drift_nu_src #(
  parameter int NW     = 16,
  parameter int N_UNIF = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 draw,
  input  logic signed [NW-1:0] mean,
  input  logic signed [NW-1:0] sigma,
  output logic signed [NW-1:0] nu_out
);
  localparam int UW     = 16;
  localparam int SUMW   = UW + $clog2(N_UNIF + 1);
  localparam int GSW    = SUMW + 1;
  localparam int PRW    = NW + GSW;
  localparam int CENTER = N_UNIF * (2 ** (UW - 1));
  localparam logic [UW-1:0] TAPS = 16'hD008;
  localparam logic signed [PRW-1:0] PMAX = PRW'(2 ** (NW - 1) - 1);
  localparam logic signed [PRW-1:0] PMIN = -PMAX - PRW'(1);

  logic [UW-1:0] lfsr [N_UNIF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_UNIF; i++) lfsr[i] <= UW'(i * 40503 + 12345) | UW'(1);
    end else begin
      for (int i = 0; i < N_UNIF; i++) lfsr[i] <= {lfsr[i][UW-2:0], ^(lfsr[i] & TAPS)};
    end
  end

  logic [SUMW-1:0]       sum;
  logic signed [GSW-1:0] gauss;
  logic signed [PRW-1:0] scaled, total;
  logic signed [NW-1:0]  nu_next;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N_UNIF; i++) sum = sum + SUMW'(lfsr[i]);
    gauss  = $signed({1'b0, sum}) - GSW'(CENTER);
    scaled = (PRW'(sigma) * PRW'(gauss)) >>> UW;
    total  = scaled + PRW'(mean);
    if (total > PMAX)      nu_next = PMAX[NW-1:0];
    else if (total < PMIN) nu_next = PMIN[NW-1:0];
    else                   nu_next = total[NW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    nu_out <= '0;
    else if (draw) nu_out <= nu_next;
  end
endmodule

// File: rtl/drift_emu_pipe.sv
// Five-stage drift pipeline: capture, log, exponent product, base change,
// exponential scaling. The whole pipe advances together under back-pressure.
module drift_emu_pipe
  import drift_pkg::*;
#(
  parameter int G_W      = 24,
  parameter int R_W      = 32,
  parameter int R_FRAC   = 16,
  parameter int NU_W     = 16,
  parameter int NU_FRAC  = 12,
  parameter int LUT_BITS = 6,
  parameter int N_UNIF   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [G_W-1:0]         in_g0,
  input  logic signed [NU_W-1:0] in_nu,
  input  logic [R_W-1:0]         in_ratio,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [G_W-1:0]         out_g,
  input  logic signed [NU_W-1:0] cfg_nu_mean,
  input  logic signed [NU_W-1:0] cfg_nu_sigma,
  input  logic                   draw,
  output logic signed [NU_W-1:0] nu_draw
);
  localparam int LN_W = 32;
  localparam int Y_W  = 48;
  localparam logic [R_W-1:0] RATIO_ONE = R_W'(1) << R_FRAC;

  logic adv;
  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  // stage valids
  logic v1, v2, v3, v4;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, v3, v4, out_valid} <= '0;
    end else if (adv) begin
      v1        <= in_valid;
      v2        <= v1;
      v3        <= v2;
      v4        <= v3;
      out_valid <= v4;
    end
  end

  // stage data
  logic [G_W-1:0]          g1, g2, g3, g4;
  logic                    byp1, byp2, byp3, byp4;
  logic signed [NU_W-1:0]  nu1, nu2;
  logic [R_W-1:0]          r1;
  logic signed [LN_W-1:0]  ln_c, ln2_q;
  logic signed [Y_W-1:0]   y3, z4;
  logic signed [Y_W-1:0]   nu_x, ln_x, nuln, z_full;
  logic [G_W-1:0]          g_exp;

  drift_log #(.RW(R_W), .RF(R_FRAC), .LB(LUT_BITS), .LNW(LN_W)) u_log (
    .ratio (r1),
    .ln_val(ln_c)
  );

  assign nu_x   = Y_W'(nu2);
  assign ln_x   = Y_W'(ln2_q);
  assign nuln   = nu_x * ln_x;
  assign z_full = y3 * Y_W'(INV_LN2_Q);

  drift_exp #(.GW(G_W), .ZW(Y_W), .LB(LUT_BITS)) u_exp (
    .g_in (g4),
    .z    (z4),
    .g_out(g_exp)
  );

  always_ff @(posedge clk) begin
    if (adv) begin
      g1    <= in_g0;
      nu1   <= in_nu;
      r1    <= in_ratio;
      byp1  <= (in_ratio <= RATIO_ONE);
      g2    <= g1;
      nu2   <= nu1;
      byp2  <= byp1;
      ln2_q <= ln_c;
      g3    <= g2;
      byp3  <= byp2;
      y3    <= (-nuln) >>> NU_FRAC;
      g4    <= g3;
      byp4  <= byp3;
      z4    <= z_full >>> LN_FRAC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   out_g <= '0;
    else if (adv) out_g <= byp4 ? g4 : g_exp;
  end

  drift_nu_src #(.NW(NU_W), .N_UNIF(N_UNIF)) u_nu (
    .clk   (clk),
    .rst_n (rst_n),
    .draw  (draw),
    .mean  (cfg_nu_mean),
    .sigma (cfg_nu_sigma),
    .nu_out(nu_draw)
  );
endmodule

// File: rtl/drift_emu_sva.sv
module drift_emu_sva #(
  parameter int GW = 24,
  parameter int NW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [GW-1:0]        out_g,
  input logic signed [NW-1:0] cfg_nu_mean,
  input logic signed [NW-1:0] cfg_nu_sigma,
  input logic                 draw,
  input logic signed [NW-1:0] nu_draw
);
  logic       live;
  logic [3:0] occ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= 1'b0;
      occ  <= '0;
    end else begin
      live <= 1'b1;
      occ  <= occ + 4'(in_valid && in_ready) - 4'(out_valid && out_ready);
    end
  end

  // R1: a waiting result is held
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_g));

  // R1: an empty output slot never blocks the input
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R2: never more cells in flight than stages, no output from nothing
  p_occ_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ <= 4'd5) && (out_valid -> occ != 4'd0));

  // R6: reset empties the pipe
  p_reset_r6: assert property (@(posedge clk)
    !rst_n |=> !out_valid && in_ready && nu_draw == '0);

  // R7: no draw, no change
  p_nu_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live && !draw |=> $stable(nu_draw));

  // R8: zero spread gives the mean
  p_sigma0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live && draw && cfg_nu_sigma == '0 |=> nu_draw == $past(cfg_nu_mean));
endmodule

bind drift_emu_pipe drift_emu_sva #(.GW(G_W), .NW(NU_W)) u_sva (.*);

// File: tb/tb_drift_emu_pipe.sv
`timescale 1ns/1ps
module tb_drift_emu_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_g0 = '0;
  logic signed [15:0] in_nu = '0;
  logic [31:0] in_ratio = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_g;
  logic signed [15:0] cfg_nu_mean = '0;
  logic signed [15:0] cfg_nu_sigma = '0;
  logic        draw = 1'b0;
  logic signed [15:0] nu_draw;

  always #2.5 clk = ~clk;

  drift_emu_pipe dut (.*);

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit stall_mode = 0, accepted = 0, held = 0;
  logic [23:0] held_g;
  int cur_exp, cur_kind;
  int q_exp[$], q_kind[$], q_stamp[$];
  bit q_lat[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // kinds: 0 pass-through (R3), 1 clamp (R5), 2 approximate (R4), 3 zero (R5)
  task automatic model(int g, int nu, longint r, output int e, output int kind);
    real x;
    if (r <= 65536) begin e = g; kind = 0; end
    else if (g == 0) begin e = 0; kind = 3; end
    else begin
      x = real'(g) * $exp(-(real'(nu) / 4096.0) * $ln(real'(r) / 65536.0));
      if (x >= 16777216.0) begin e = 24'hFFFFFF; kind = 1; end
      else begin e = $rtoi(x + 0.5); kind = 2; end
    end
  endtask

  task automatic tick();
    int e, k, s, d;
    bit l;
    out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    #1;
    if (held) check(out_valid && out_g == held_g, "R1", "held result", out_g, held_g);
    held   = out_valid && !out_ready;
    held_g = out_g;
    if (out_valid && out_ready) begin
      if (q_exp.size() == 0) check(0, "R2", "result without cell", out_g, 0);
      else begin
        e = q_exp.pop_front(); k = q_kind.pop_front();
        s = q_stamp.pop_front(); l = q_lat.pop_front();
        if (l) check(cyc - s == 5, "R2", "latency", cyc - s, 5);
        if (k == 0)      check(out_g == e, "R3", "pass-through", out_g, e);
        else if (k == 1) check(out_g == e, "R5", "clamp", out_g, e);
        else if (k == 3) check(out_g == 0, "R5", "zero conductance", out_g, 0);
        else begin
          d = int'(out_g) - e;
          if (d < 0) d = -d;
          check(real'(d) <= real'(e) * 0.03 + 2.0, "R4", "drifted value", out_g, e);
        end
      end
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      q_exp.push_back(cur_exp); q_kind.push_back(cur_kind);
      q_stamp.push_back(cyc); q_lat.push_back(!stall_mode);
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic send(int g, int nu, longint r);
    in_g0 = 24'(g); in_nu = 16'(nu); in_ratio = 32'(r);
    model(g, nu, r, cur_exp, cur_kind);
    in_valid = 1'b1;
    do tick(); while (!accepted);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_exp.size() != 0 || held) tick();
  endtask

  task automatic do_draw();
    draw = 1'b1;
    tick();
    draw = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6
    check(out_valid == 0, "R6", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R6", "in_ready after reset", in_ready, 1);
    check(nu_draw == 0, "R6", "nu_draw after reset", nu_draw, 0);

    // directed cells (R3, R4, R5)
    send(5 << 16, -8192, 0);                 // R3 ratio zero, growth exponent ignored
    send(5 << 16, -8192, 65536);             // R3 ratio exactly one
    send(24'hFFFFFF, 4096, 65536);           // R3 full-scale code passes
    send(10 << 16, 205, 65537);              // R4 just above one
    send(40 << 16, 410, 64'd32768 << 16);    // R4 long decay
    send(50 << 16, 4096, 100 << 16);         // R4 nu = 1.0
    send(20 << 16, -2048, 4 << 16);          // R4 growth nu = -0.5
    send(3 << 16, 32767, 60000 << 16);       // R4 vanishes towards zero
    send(10 << 16, -4096, 1000 << 16);       // R5 clamp
    send(1, -32768, 32'hFFFFFFFF);           // R5 huge growth from one LSB
    send(0, -16384, 32'hFFFFFFFF);           // R5 zero conductance stays zero
    drain();

    // back-to-back random cells, no back-pressure (R2, R3, R4)
    for (int i = 0; i < 60; i++) begin
      longint r;
      r = (i % 7 == 0) ? longint'($urandom_range(0, 65536))
                       : longint'($urandom & 32'h00FF_FFFF) + 65537;
      send(int'($urandom_range(0, 100 << 16)), int'($urandom_range(0, 819)), r);
    end
    drain();

    // random back-pressure (R1, R2)
    stall_mode = 1;
    for (int i = 0; i < 80; i++) begin
      send(int'($urandom_range(0, 100 << 16)), int'($urandom_range(0, 819)),
           longint'($urandom & 32'h003F_FFFF));
    end
    drain();
    stall_mode = 0;
    drain();

    // exponent source: zero spread (R8)
    cfg_nu_mean = 16'sd256; cfg_nu_sigma = 16'sd0;
    do_draw();
    check(nu_draw == 16'sd256, "R8", "zero-sigma draw", nu_draw, 256);
    cfg_nu_mean = -16'sd300;
    do_draw();
    check(nu_draw == -16'sd300, "R8", "zero-sigma negative mean", nu_draw, -300);

    // hold and change (R7)
    begin
      logic signed [15:0] v0, v1;
      cfg_nu_mean = 16'sd0; cfg_nu_sigma = 16'sd4096;
      do_draw();
      v0 = nu_draw;
      repeat (5) tick();
      check(nu_draw == v0, "R7", "hold without draw", nu_draw, v0);
      repeat (9) tick();
      do_draw();
      v1 = nu_draw;
      check(v1 != v0, "R7", "new value per draw", v1, v0);
    end

    // statistics (R9)
    begin
      real sm, sq, mu, var_v;
      int out_of_band;
      sm = 0.0; sq = 0.0; out_of_band = 0;
      for (int i = 0; i < 400; i++) begin
        do_draw();
        sm += real'(nu_draw) / 4096.0;
        sq += (real'(nu_draw) / 4096.0) ** 2;
        if (nu_draw > 16'sd24576 || nu_draw < -16'sd24576) out_of_band++;
        repeat (6) tick();
      end
      mu    = sm / 400.0;
      var_v = sq / 400.0 - mu * mu;
      check(mu > -0.25 && mu < 0.25, "R9", "sample mean x1000",
            longint'($rtoi(mu * 1000.0)), 0);
      check(var_v > 0.3 && var_v < 2.0, "R9", "sample variance x1000",
            longint'($rtoi(var_v * 1000.0)), 1000);
      check(out_of_band == 0, "R9", "draws beyond six sigma", out_of_band, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", 200000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule